// File: doc/BRIEF.md
# Beam-Break Overspeed Detector

This block decides whether a vehicle has crossed a measured stretch of road faster than a chosen speed limit. Two light beams cross the road a fixed distance apart. When the vehicle breaks the first beam, the block opens a timing window. The length of that window follows from the limit in force. If the vehicle then breaks the second beam before the window has closed, it was travelling too fast, and the block raises an alarm output for a fixed time.

The beam inputs are already debounced. They read high while light reaches the sensor and low while the beam is blocked. Both pass through a two-flop synchronizer, and only the light-to-dark edge counts. All durations are counted in cycles of a 100 Hz enable tick that an outside prescaler supplies. With the default settings, the window lasts 900 ticks (9 s) at the lower limit and 600 ticks (6 s) at the higher one. The alarm lasts 200 ticks and the second-beam pulse lasts 5 ticks. An operator reset button closes the window. The three outputs drive the indicator lamps and the buzzer stage.

Top module: `overspeed_detector`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `window_o`, `stop_o` and `alarm_o` are all low.
- R2: A high-to-low transition on `start_beam_n_i` opens the window. A beam that stays low opens it only once.
- R3: The window lasts WIN_SLOW_TICKS ticks when `limit_fast_i` is 0 at the moment of opening, and WIN_FAST_TICKS ticks when it is 1. Changing `limit_fast_i` while the window is open does not alter its length.
- R4: A start-beam break while the window is open is ignored, so the window closes at its original time.
- R5: A high-to-low transition on `stop_beam_n_i` raises `stop_o` for STOP_TICKS ticks. It does so whether or not the window is open.
- R6: When `stop_o` rises while `window_o` is high, `alarm_o` rises one cycle later and stays high for ALARM_TICKS ticks.
- R7: A stop event while no window is open produces no alarm.
- R8: A cycle with `rst_btn_i` high closes the window from the next cycle onward. A later stop event then produces no alarm.
- R9: Every duration advances only in cycles where `tick_i` is high. Without ticks, an open window stays open.
- R10: `window_o` goes high on the third rising clock edge after a start-beam input falls (two synchronizer stages and one counter load). `stop_o` follows the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_btn_i | input | 1 | Operator reset button, closes the window |
| tick_i | input | 1 | 100 Hz enable from the prescaler |
| limit_fast_i | input | 1 | Limit select: 0 = lower limit (long window), 1 = higher limit (short window) |
| start_beam_n_i | input | 1 | First beam, high = light, low = blocked |
| stop_beam_n_i | input | 1 | Second beam, high = light, low = blocked |
| window_o | output | 1 | Timing window open |
| stop_o | output | 1 | Second-beam pulse active |
| alarm_o | output | 1 | Overspeed alarm |

## Verification
The case that is hardest to reach from the ports is a stop event landing on the last open tick of the window, or on the first tick after it closes. That boundary lies hundreds of cycles after the first beam break and depends on which limit was latched. The stimulus counts the gap between the two beam breaks in clock cycles with the tick running every cycle. It draws gaps at random, clustering them within a few cycles of the window length for both limits, and adds directed gaps of exactly one less than the length and equal to it. Directed runs also cover a held tick, a start-beam break while the window is open, a limit change mid-window and a button press.

// File: rtl/ovs_pkg.sv
package ovs_pkg;

    // Speed-limit selector encoding
    typedef enum logic {
        LIM_SLOW = 1'b0,   // lower limit, longer window
        LIM_FAST = 1'b1    // higher limit, shorter window
    } limit_e;

    // Output indicator bundle
    typedef struct packed {
        logic window;
        logic stop;
        logic alarm;
    } ovs_flags_t;

    // Beam index constants
    localparam int BEAM_START = 0;
    localparam int BEAM_STOP  = 1;
    localparam int NUM_BEAMS  = 2;

    // Pick window length from the selected limit
    function automatic int unsigned win_len(input limit_e lim,
                                            input int unsigned slow_t,
                                            input int unsigned fast_t);
        return (lim == LIM_FAST) ? fast_t : slow_t;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ovs_beam_sync.sv
module ovs_beam_sync (
    input  logic clk,
    input  logic rst,
    input  logic beam_n_i,
    output logic fall_o
);
    // Two synchronizer stages plus one history stage; idle level is light (1)
    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= beam_n_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Light-to-dark transition on the synchronized level
    assign fall_o = prev_q & ~sync_q;

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o); // R2

endmodule

// File: rtl/ovs_oneshot.sv
module ovs_oneshot #(
    parameter int unsigned MAXV = 900,
    localparam int CW = $clog2(MAXV + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          tick_i,
    input  logic          trig_i,
    input  logic [CW-1:0] load_i,
    output logic          active_o
);
    logic [CW-1:0] cnt_q;
    logic          idle;

    assign idle = (cnt_q == '0);

    // Clear beats trigger; trigger only loads when idle (no retrigger);
    // countdown only on tick cycles
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (trig_i && idle) begin
            cnt_q <= load_i;
        end else if (tick_i && !idle) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active_o = !idle;

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !active_o); // R8

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !tick_i && !idle) |=> (cnt_q == $past(cnt_q))); // R9

    AST_NO_RETRIG: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && trig_i && !idle) |=> (cnt_q <= $past(cnt_q))); // R4

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(MAXV)); // R3

endmodule

// File: rtl/overspeed_detector.sv
module overspeed_detector #(
    parameter int unsigned WIN_SLOW_TICKS = 900,
    parameter int unsigned WIN_FAST_TICKS = 600,
    parameter int unsigned ALARM_TICKS    = 200,
    parameter int unsigned STOP_TICKS     = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_btn_i,
    input  logic tick_i,
    input  logic limit_fast_i,
    input  logic start_beam_n_i,
    input  logic stop_beam_n_i,
    output logic window_o,
    output logic stop_o,
    output logic alarm_o
);
    import ovs_pkg::*;

    localparam int unsigned WIN_MAX = max2(WIN_SLOW_TICKS, WIN_FAST_TICKS);
    localparam int WIN_W   = $clog2(WIN_MAX + 1);
    localparam int ALARM_W = $clog2(ALARM_TICKS + 1);
    localparam int STOP_W  = $clog2(STOP_TICKS + 1);

    logic [NUM_BEAMS-1:0] beam_n;
    logic [NUM_BEAMS-1:0] beam_fall;

    assign beam_n[BEAM_START] = start_beam_n_i;
    assign beam_n[BEAM_STOP]  = stop_beam_n_i;

    for (genvar b = 0; b < NUM_BEAMS; b++) begin : g_sync
        ovs_beam_sync u_sync (
            .clk      (clk),
            .rst      (rst),
            .beam_n_i (beam_n[b]),
            .fall_o   (beam_fall[b])
        );
    end

    // Limit latched into the counter at window opening
    limit_e           lim_sel;
    logic [WIN_W-1:0] win_load;

    assign lim_sel  = limit_e'(limit_fast_i);
    assign win_load = WIN_W'(win_len(lim_sel, WIN_SLOW_TICKS, WIN_FAST_TICKS));

    ovs_flags_t flags;

    ovs_oneshot #(.MAXV(WIN_MAX)) u_window (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (rst_btn_i),
        .tick_i   (tick_i),
        .trig_i   (beam_fall[BEAM_START]),
        .load_i   (win_load),
        .active_o (flags.window)
    );

    ovs_oneshot #(.MAXV(STOP_TICKS)) u_stop (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (1'b0),
        .tick_i   (tick_i),
        .trig_i   (beam_fall[BEAM_STOP]),
        .load_i   (STOP_W'(STOP_TICKS)),
        .active_o (flags.stop)
    );

    // Violation: stop pulse and window overlap; alarm fires on onset of overlap
    logic overlap;
    logic overlap_q;

    assign overlap = flags.window & flags.stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            overlap_q <= 1'b0;
        end else begin
            overlap_q <= overlap;
        end
    end

    ovs_oneshot #(.MAXV(ALARM_TICKS)) u_alarm (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (1'b0),
        .tick_i   (tick_i),
        .trig_i   (overlap & ~overlap_q),
        .load_i   (ALARM_W'(ALARM_TICKS)),
        .active_o (flags.alarm)
    );

    assign window_o = flags.window;
    assign stop_o   = flags.stop;
    assign alarm_o  = flags.alarm;

    AST_ALARM_NEEDS_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_o) |-> $past(window_o && stop_o)); // R6

    AST_STOP_FOLLOWS_EDGE: assert property (@(posedge clk) disable iff (rst)
        beam_fall[BEAM_STOP] |=> stop_o); // R5

    AST_NO_ALARM_WITHOUT_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (stop_o && !window_o && !alarm_o && !overlap_q) |=> !alarm_o); // R7

endmodule

// File: tb/overspeed_detector_tb.sv
module overspeed_detector_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SLOW_T  = 900;
    localparam int FAST_T  = 600;
    localparam int ALARM_T = 200;
    localparam int STOP_T  = 5;
    localparam int BREAK_CYC = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_btn_i = 1'b0;
    logic tick_i = 1'b1;
    logic limit_fast_i = 1'b0;
    logic start_beam_n_i = 1'b1;
    logic stop_beam_n_i = 1'b1;
    logic window_o, stop_o, alarm_o;

    int errors = 0;
    int checks = 0;
    int win_cnt = 0;
    int stop_cnt = 0;
    int alarm_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    overspeed_detector #(
        .WIN_SLOW_TICKS(SLOW_T), .WIN_FAST_TICKS(FAST_T),
        .ALARM_TICKS(ALARM_T), .STOP_TICKS(STOP_T)
    ) dut_i (
        .clk(clk), .rst(rst), .rst_btn_i(rst_btn_i), .tick_i(tick_i),
        .limit_fast_i(limit_fast_i), .start_beam_n_i(start_beam_n_i),
        .stop_beam_n_i(stop_beam_n_i), .window_o(window_o),
        .stop_o(stop_o), .alarm_o(alarm_o)
    );

    // Output monitors, sampled away from the active edge
    always @(negedge clk) begin
        if (window_o) win_cnt++;
        if (stop_o)   stop_cnt++;
        if (alarm_o)  alarm_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input bit fast);
        return fast ? FAST_T : SLOW_T;
    endfunction

    function automatic int exp_alarm(input bit fast, input int gap);
        return (gap < exp_len(fast)) ? ALARM_T : 0;
    endfunction

    task automatic clear_counts();
        @(posedge clk);
        win_cnt = 0; stop_cnt = 0; alarm_cnt = 0;
    endtask

    task automatic settle();
        repeat (SLOW_T + ALARM_T + 40) @(negedge clk);
    endtask

    // Start break at cycle 0, stop break at cycle gap (gap < 0: no stop)
    task automatic trial(input bit fast, input int gap, input int restart_at,
                         input int flip_at);
        int last;
        clear_counts();
        limit_fast_i = fast;
        last = (gap > restart_at ? gap : restart_at) + BREAK_CYC + 2;
        for (int c = 0; c < last; c++) begin
            @(negedge clk);
            start_beam_n_i = !((c < BREAK_CYC) ||
                               (restart_at > 0 && c >= restart_at && c < restart_at + BREAK_CYC));
            stop_beam_n_i  = !(gap >= 0 && c >= gap && c < gap + BREAK_CYC);
            if (flip_at > 0 && c == flip_at) limit_fast_i = !fast;
        end
        start_beam_n_i = 1'b1;
        stop_beam_n_i  = 1'b1;
        settle();
    endtask

    initial begin
        #(CLK_PERIOD * 180000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 window in reset", window_o, 0);
        chk("R1 alarm in reset", alarm_o, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 outputs after release", {window_o, stop_o, alarm_o}, 0);

        // R10 latency: input falls at a negedge, window on third rising edge
        clear_counts();
        @(negedge clk); limit_fast_i = 1'b1; start_beam_n_i = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R10 window not yet open", window_o, 0);
        @(negedge clk);
        chk("R10 window open on third edge", window_o, 1);
        repeat (20) @(negedge clk);
        start_beam_n_i = 1'b1;
        settle();
        chk("R2 held low opens once", win_cnt, FAST_T);

        // R7: stop without window
        trial(1'b0, 10, 0, 0);
        win_cnt = win_cnt; // no-op keeps counts
        clear_counts();
        @(negedge clk); stop_beam_n_i = 1'b0;
        repeat (BREAK_CYC) @(negedge clk);
        stop_beam_n_i = 1'b1;
        settle();
        chk("R5 lone stop pulse width", stop_cnt, STOP_T);
        chk("R7 no alarm without window", alarm_cnt, 0);
        chk("R7 no window from stop", win_cnt, 0);

        // R4: restart during window ignored
        trial(1'b1, -1, 300, 0);
        chk("R4 no retrigger", win_cnt, FAST_T);

        // R3: limit change mid-window ignored
        trial(1'b1, -1, 0, 100);
        chk("R3 fast latched", win_cnt, FAST_T);
        trial(1'b0, -1, 0, 100);
        chk("R3 slow latched", win_cnt, SLOW_T);

        // R6 boundary gaps
        trial(1'b1, FAST_T - 1, 0, 0);
        chk("R6 fast last tick alarm", alarm_cnt, ALARM_T);
        trial(1'b1, FAST_T, 0, 0);
        chk("R7 fast after close no alarm", alarm_cnt, 0);
        trial(1'b0, SLOW_T - 1, 0, 0);
        chk("R6 slow last tick alarm", alarm_cnt, ALARM_T);
        chk("R5 stop width in window", stop_cnt, STOP_T);
        trial(1'b0, SLOW_T, 0, 0);
        chk("R7 slow after close no alarm", alarm_cnt, 0);

        // R6 alarm onset one cycle after stop_o
        clear_counts();
        limit_fast_i = 1'b1;
        @(negedge clk); start_beam_n_i = 1'b0; stop_beam_n_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 stop_o on third edge", stop_o, 1);
        chk("R6 alarm not same cycle", alarm_o, 0);
        @(negedge clk);
        chk("R6 alarm next cycle", alarm_o, 1);
        start_beam_n_i = 1'b1; stop_beam_n_i = 1'b1;
        settle();

        // R9: no ticks holds window
        clear_counts();
        tick_i = 1'b0; limit_fast_i = 1'b1;
        @(negedge clk); start_beam_n_i = 1'b0;
        repeat (BREAK_CYC) @(negedge clk);
        start_beam_n_i = 1'b1;
        repeat (1000) @(negedge clk);
        chk("R9 window held without tick", window_o, 1);
        tick_i = 1'b1;
        repeat (FAST_T - 1) @(negedge clk);
        chk("R9 window still open", window_o, 1);
        repeat (2) @(negedge clk);
        chk("R9 window closes after ticks", window_o, 0);
        settle();

        // R8: button closes window, later stop no alarm
        clear_counts();
        limit_fast_i = 1'b0;
        @(negedge clk); start_beam_n_i = 1'b0;
        repeat (50) @(negedge clk);
        start_beam_n_i = 1'b1;
        rst_btn_i = 1'b1;
        @(negedge clk); rst_btn_i = 1'b0;
        chk("R8 window closed by button", window_o, 0);
        repeat (20) @(negedge clk);
        stop_beam_n_i = 1'b0;
        repeat (BREAK_CYC) @(negedge clk);
        stop_beam_n_i = 1'b1;
        settle();
        chk("R8 no alarm after button", alarm_cnt, 0);

        // Random trials around and away from the boundary
        for (int i = 0; i < 24; i++) begin
            bit fast;
            int gap;
            fast = bit'($urandom % 2);
            if (i % 2 == 0) gap = exp_len(fast) - 4 + int'($urandom % 8);
            else            gap = int'($urandom % (exp_len(fast) + 60));
            trial(fast, gap, 0, 0);
            chk("R3 random window length", win_cnt, exp_len(fast));
            chk("R6 random alarm length", alarm_cnt, exp_alarm(fast, gap));
            chk("R5 random stop width", stop_cnt, STOP_T);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule